// File: doc/BRIEF.md
# Variable-Latency Multiplier with Adaptive Hold

This block multiplies two unsigned operands and takes either one or two cycles per operation, depending on the operand pattern. When an operand is accepted, a hold judge counts the zero bits of the multiplicand. If there are enough zeros, the operation is attempted on a fast path. Otherwise it takes the full two-cycle path. Operands come in through a valid/ready handshake. Each result is presented for one cycle, together with an error bit and an aged bit.

The fast path stands in for logic whose timing has worsened. The value it produces is exact only for patterns that carry at least a configurable number of zero bits. A shadow value, which is always the exact product, is compared with the fast value. On a mismatch the result is dropped and the operation is run again over two cycles. The result that comes out carries the error bit.

An aging meter counts completed operations in fixed windows and counts the errors within each window. Once one window holds more errors than a limit, the meter raises a sticky aged flag. From then on the judge applies a stricter zero-count rule, so that fewer operations are tried on the fast path.

Top module: `varlat_mult`

## Requirements
- R1: Whenever `out_valid` is high, `out_product` equals the unsigned product of the accepted `in_a` and `in_b`, 2·W bits wide.
- R2: After reset, `in_ready` is 1, and `out_valid`, `out_err`, `out_aged` and `out_product` are all 0.
- R3: An operand pair is taken in on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until the cycle in which that result is shown. In that cycle `in_ready` is 1 again, so a new pair can be accepted at once.
- R4: The zero count of `in_a` (the number of 0 bits) decides the path. While not aged, a count of at least W/2 selects a fast attempt. A smaller count gives a two-cycle operation, whose result appears 2 cycles after the accepting edge with `out_err` = 0.
- R5: A fast attempt whose multiplicand has at least FAST_ZEROS zero bits (default W/2+1) is exact. Its result appears 1 cycle after the accepting edge with `out_err` = 0.
- R6: A fast attempt whose multiplicand has fewer than FAST_ZEROS zero bits produces a wrong fast value. This is caught against the shadow value, and the operation is rerun over two more cycles. The exact result appears 3 cycles after the accepting edge, with `out_err` = 1 in the same cycle as `out_valid`.
- R7: Every delivered result counts as one operation of the current window. After the WINDOW-th operation (default 256), the operation count and the error count both return to 0.
- R8: `out_aged` rises in the cycle of the result that takes the error count of the current window above AGE_LIMIT (default 16). It stays at 1 until reset.
- R9: While `out_aged` is 1, the fast attempt requires at least W/2+1 zero bits. A multiplicand with exactly W/2 zeros then takes the two-cycle path without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle and able to take an operand pair |
| in_a | input | W | Multiplicand, the operand whose zero count is judged |
| in_b | input | W | Multiplier |
| out_valid | output | 1 | One-cycle pulse marking a result |
| out_product | output | 2·W | Unsigned product |
| out_err | output | 1 | Result came from a replay after a fast-path mismatch |
| out_aged | output | 1 | Sticky flag: the strict judging rule is in force |

## Verification
The bench builds the block with W = 4, WINDOW = 16 and AGE_LIMIT = 3, and keeps FAST_ZEROS at 3. With these values all 256 operand pairs can be swept, and the expected latency, error bit and aged bit come from a small arithmetic model. The short window makes it cheap to run several full windows that each hold exactly the limit of errors, which checks that the counters clear at the window boundary. A fourth error inside one window then shows the switch to the strict rule, and a multiplicand such as 0011 can be seen moving from the replay path to the two-cycle path.

// File: rtl/vlm_pkg.sv
package vlm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FAST  = 2'd1,
        ST_SLOW1 = 2'd2,
        ST_SLOW2 = 2'd3
    } vlm_state_e;

endpackage

// File: rtl/vlm_zero_count.sv
module vlm_zero_count #(
    parameter int W  = 8,
    parameter int ZW = $clog2(W + 1)
) (
    input  logic [W-1:0]  value,
    output logic [ZW-1:0] zeros
);

    always_comb begin
        zeros = '0;
        for (int i = 0; i < W; i++) begin
            zeros = zeros + ZW'(!value[i]);
        end
    end

endmodule

// File: rtl/vlm_hold_judge.sv
module vlm_hold_judge #(
    parameter int W  = 8,
    parameter int ZW = $clog2(W + 1)
) (
    input  logic [ZW-1:0] zeros,
    input  logic          aged,
    output logic          one_cycle
);

    localparam logic [ZW-1:0] RELAXED_MIN = ZW'(W / 2);
    localparam logic [ZW-1:0] STRICT_MIN  = ZW'(W / 2 + 1);

    always_comb begin
        one_cycle = (zeros >= (aged ? STRICT_MIN : RELAXED_MIN));
    end

endmodule

// File: rtl/vlm_fast_path.sv
module vlm_fast_path #(
    parameter int W          = 8,
    parameter int FAST_ZEROS = W / 2 + 1,
    parameter int ZW         = $clog2(W + 1)
) (
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    input  logic [ZW-1:0]  zeros,
    output logic [2*W-1:0] main_val,
    output logic [2*W-1:0] shadow_val
);

    localparam int PW = 2 * W;
    localparam logic [ZW-1:0] SAFE_MIN = ZW'(FAST_ZEROS);

    always_comb begin
        shadow_val = {{W{1'b0}}, op_a} * {{W{1'b0}}, op_b};
        // emulated late capture: wrong in the LSB for dense patterns
        main_val   = (zeros >= SAFE_MIN) ? shadow_val : (shadow_val ^ PW'(1));
    end

endmodule

// File: rtl/vlm_aging_meter.sv
module vlm_aging_meter #(
    parameter int WINDOW    = 256,
    parameter int AGE_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic op_done,
    input  logic op_err,
    output logic aged
);

    localparam int OW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam int EW = $clog2(AGE_LIMIT + 2);
    localparam logic [OW-1:0] LAST_OP  = OW'(WINDOW - 1);
    localparam logic [EW-1:0] ERR_SAT  = EW'(AGE_LIMIT + 1);
    localparam logic [EW-1:0] ERR_LIM  = EW'(AGE_LIMIT);

    typedef struct packed {
        logic [OW-1:0] ops;
        logic [EW-1:0] errs;
        logic          aged;
    } meter_t;

    meter_t m_d, m_q;
    logic [EW-1:0] errs_bump;

    always_comb begin
        m_d       = m_q;
        errs_bump = m_q.errs;
        if (op_done) begin
            if (op_err && (m_q.errs != ERR_SAT)) begin
                errs_bump = m_q.errs + 1'b1;
            end
            if (errs_bump > ERR_LIM) begin
                m_d.aged = 1'b1;
            end
            if (m_q.ops == LAST_OP) begin
                m_d.ops  = '0;
                m_d.errs = '0;
            end else begin
                m_d.ops  = m_q.ops + 1'b1;
                m_d.errs = errs_bump;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign aged = m_q.aged;

    AST_AGED_STICKY: assert property (@(posedge clk) disable iff (!rst_n) m_q.aged |=> m_q.aged) else $error("aged flag dropped"); // R8
    AST_WINDOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (op_done && m_q.ops == LAST_OP) |=> (m_q.ops == '0 && m_q.errs == '0)) else $error("window did not clear"); // R7

endmodule

// File: rtl/varlat_mult.sv
module varlat_mult #(
    parameter int W          = 8,
    parameter int FAST_ZEROS = W / 2 + 1,
    parameter int WINDOW     = 256,
    parameter int AGE_LIMIT  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [W-1:0]   in_a,
    input  logic [W-1:0]   in_b,
    output logic           out_valid,
    output logic [2*W-1:0] out_product,
    output logic           out_err,
    output logic           out_aged
);

    import vlm_pkg::*;

    localparam int PW = 2 * W;
    localparam int ZW = $clog2(W + 1);

    typedef struct packed {
        vlm_state_e    st;
        logic [W-1:0]  a;
        logic [W-1:0]  b;
        logic [ZW-1:0] zc;
        logic          replay;
        logic [PW-1:0] prod;
        logic          vld;
        logic          err;
    } core_t;

    core_t r_d, r_q;

    logic [ZW-1:0] in_zeros;
    logic          take_fast;
    logic          aged;
    logic [PW-1:0] main_val;
    logic [PW-1:0] shadow_val;

    vlm_zero_count #(.W(W), .ZW(ZW)) u_zeros (
        .value (in_a),
        .zeros (in_zeros)
    );

    vlm_hold_judge #(.W(W), .ZW(ZW)) u_judge (
        .zeros     (in_zeros),
        .aged      (aged),
        .one_cycle (take_fast)
    );

    vlm_fast_path #(.W(W), .FAST_ZEROS(FAST_ZEROS), .ZW(ZW)) u_fast (
        .op_a       (r_q.a),
        .op_b       (r_q.b),
        .zeros      (r_q.zc),
        .main_val   (main_val),
        .shadow_val (shadow_val)
    );

    vlm_aging_meter #(.WINDOW(WINDOW), .AGE_LIMIT(AGE_LIMIT)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_done (r_d.vld),
        .op_err  (r_d.err),
        .aged    (aged)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        r_d.err = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    r_d.a      = in_a;
                    r_d.b      = in_b;
                    r_d.zc     = in_zeros;
                    r_d.replay = 1'b0;
                    r_d.st     = take_fast ? ST_FAST : ST_SLOW1;
                end
            end
            ST_FAST: begin
                if (main_val == shadow_val) begin
                    r_d.prod = main_val;
                    r_d.vld  = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.replay = 1'b1;
                    r_d.st     = ST_SLOW1;
                end
            end
            ST_SLOW1: begin
                r_d.st = ST_SLOW2;
            end
            ST_SLOW2: begin
                r_d.prod   = shadow_val;
                r_d.vld    = 1'b1;
                r_d.err    = r_q.replay;
                r_d.replay = 1'b0;
                r_d.st     = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready    = (r_q.st == ST_IDLE);
    assign out_valid   = r_q.vld;
    assign out_product = r_q.prod;
    assign out_err     = r_q.err;
    assign out_aged    = aged;

    AST_ONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> !in_ready) else $error("second operand accepted while busy"); // R3
    AST_RESULT_EXACT: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_product == ({{W{1'b0}}, r_q.a} * {{W{1'b0}}, r_q.b}))) else $error("product mismatch"); // R1
    AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n) out_err |-> out_valid) else $error("error bit without result"); // R6
    AST_ERR_AFTER_REPLAY: assert property (@(posedge clk) disable iff (!rst_n) out_err |-> $past(r_q.st == ST_SLOW2)) else $error("error bit outside replay"); // R6
    AST_FAST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && $past(r_q.st == ST_FAST)) |-> !out_err) else $error("fast result flagged"); // R5

endmodule

// File: tb/tb_varlat_mult.sv
`timescale 1ns/1ps
module tb_varlat_mult;

    localparam int W      = 4;
    localparam int WIN    = 16;
    localparam int LIMIT  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [W-1:0]   in_a = '0;
    logic [W-1:0]   in_b = '0;
    logic           out_valid;
    logic [2*W-1:0] out_product;
    logic           out_err;
    logic           out_aged;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    bit  aged_m = 1'b0;
    int  ops_m  = 0;
    int  ec_m   = 0;

    always #2 clk = ~clk;

    varlat_mult #(.W(W), .WINDOW(WIN), .AGE_LIMIT(LIMIT)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_a        (in_a),
        .in_b        (in_b),
        .out_valid   (out_valid),
        .out_product (out_product),
        .out_err     (out_err),
        .out_aged    (out_aged)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int zeros4(input logic [W-1:0] v);
        int z = 0;
        for (int i = 0; i < W; i++) if (!v[i]) z++;
        return z;
    endfunction

    task automatic do_reset();
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n  = 1'b1;
        aged_m = 1'b0;
        ops_m  = 0;
        ec_m   = 0;
        check(in_ready == 1'b1, "R2", "ready after reset", in_ready, 1);
        check(out_valid == 1'b0, "R2", "valid after reset", out_valid, 0);
        check(out_err == 1'b0, "R2", "err after reset", out_err, 0);
        check(out_aged == 1'b0, "R2", "aged after reset", out_aged, 0);
        check(out_product == '0, "R2", "product after reset", out_product, 0);
    endtask

    // starts and ends at a falling edge
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input string age_tag);
        int    z;
        int    lat_e;
        bit    err_e;
        int    lat;
        bit    seen;
        string tag;
        z = zeros4(a);
        if (z >= (aged_m ? 3 : 2)) begin
            if (z >= 3) begin lat_e = 1; err_e = 1'b0; tag = "R5"; end
            else        begin lat_e = 3; err_e = 1'b1; tag = "R6"; end
        end else begin
            lat_e = 2; err_e = 1'b0;
            tag = (aged_m && z == 2) ? "R9" : "R4";
        end
        check(in_ready == 1'b1, "R3", "ready before issue", in_ready, 1);
        in_valid = 1'b1;
        in_a     = a;
        in_b     = b;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R3", "ready low after accept", in_ready, 0);
        lat  = 0;
        seen = 1'b0;
        while (!seen && lat < 6) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (out_valid) seen = 1'b1;
            else check(in_ready == 1'b0, "R3", "ready low while pending", in_ready, 0);
        end
        check(seen, tag, "result appeared", seen, 1);
        check(lat == lat_e, tag, "latency", lat, lat_e);
        check(out_err == err_e, tag, "error bit", out_err, err_e);
        check(out_product == a * b, "R1", "product", out_product, a * b);
        check(in_ready == 1'b1, "R3", "ready in result cycle", in_ready, 1);
        ops_m++;
        if (err_e) ec_m++;
        if (ec_m > LIMIT) aged_m = 1'b1;
        if (ops_m == WIN) begin ops_m = 0; ec_m = 0; end
        check(out_aged == aged_m, age_tag, "aged flag", out_aged, aged_m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R7: three full windows, each holding exactly LIMIT errors
        for (int w = 0; w < 3; w++) begin
            for (int k = 0; k < WIN - LIMIT; k++) run_op(4'b0001, 4'(k), "R7");
            for (int k = 0; k < LIMIT; k++)       run_op(4'b0011, 4'(k + 5), "R7");
        end
        check(out_aged == 1'b0, "R7", "not aged after cleared windows", out_aged, 0);

        // R8: one error over the limit within a window
        for (int k = 0; k < LIMIT + 1; k++) run_op(4'b0011, 4'hF - 4'(k), "R8");
        check(out_aged == 1'b1, "R8", "aged after limit crossed", out_aged, 1);

        // R9: strict rule now; R4/R5 paths unchanged
        run_op(4'b0101, 4'hD, "R8");
        run_op(4'b1111, 4'hF, "R8");
        run_op(4'b1000, 4'h9, "R8");
        run_op(4'b0000, 4'h7, "R8");
        repeat (20) run_op(4'b1010, 4'h3, "R8");
        check(out_aged == 1'b1, "R8", "aged survives window end", out_aged, 1);

        do_reset();

        // exhaustive sweep against the model
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                run_op(4'(a), 4'(b), "R8");
            end
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule